// File: doc/BRIEF.md
# Parallel Flash Command Register Interface

This block is the device-side command front end of a 16-bit parallel flash memory. It watches the chip-enable, output-enable and write-enable strobes with the address and data buses, a flag that says the programming supply is high, and a flag that says the core supply is above its lockout level. From those pins it decodes one- and two-cycle commands, keeps track of the operating mode, and latches the address and data that a program or verify step needs.

It starts and stops an internal pulse timer for program and erase. The timer runs until a further write ends it or a parameterised tick count expires. It steers the read data either from the cell array port or from two fixed identification codes. All pins are first synchronised to the block clock, and write-enable edges are found from the synchronised samples. A pin change sampled at clock edge k therefore reaches the mode register at edge k+2, and reaches the read outputs after edge k+1.

The cell array, the high-voltage switches and the sense path are outside the block. They are reached through a plain address/data port.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset, `mode` is 0 (read), `busy`, `pulse_stop`, `pulse_erase` and `dout_en` are 0.
- R2: A command is the low data byte at a write-enable rising edge, taken while chip enable is low and output enable is high. Decoding is 00h read (mode 0), 90h signature (mode 1), 20h erase setup (mode 2), 40h program setup (mode 5), A0h erase verify (mode 4), C0h program verify (mode 7) and FFh first reset cycle (mode 8). Any other code selects read.
- R3: No command is taken while the programming-supply flag is low. Write enable is ignored entirely while the supply-ok flag is low. In both cases `mode` holds.
- R4: A write-enable pulse while chip enable and output enable are both low changes nothing.
- R5: From erase setup, a second 20h enters erase (mode 3) and starts an erase pulse. Any other code returns to read with no pulse, except FFh, which counts as a first reset cycle (mode 8).
- R6: Two consecutive FFh writes return the block to read. A pulse running at the first FFh ends at that write.
- R7: The write after program setup latches the address at the write-enable falling edge and the data at its rising edge. It enters mode 6 and starts a program pulse, which a later write-enable rising edge ends.
- R8: Writing A0h ends a running erase pulse and enters mode 4. The address present at that write's falling edge becomes the verify address.
- R9: A pulse that no write ends holds `busy` high for exactly PGM_TICKS (program) or ERS_TICKS (erase) cycles. `pulse_stop` is high for the one cycle after any pulse ends, and `pulse_erase` shows the kind of the last pulse.
- R10: In signature mode, reads of address 0000h give 0031h, reads of 0001h give 0051h, and reads of any other address give 0000h.
- R11: `dout_en` is high only while chip enable and output enable are low and write enable is high. Outside signature mode, `dout` is `array_rdata`. `cell_addr` is the latched address in modes 4, 6 and 7, and the pin address otherwise.
- R12: Program verify keeps the address latched by the last program write. A verify-command write does not replace it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| addr | input | AW | Address pins |
| din | input | DW | Data bus as seen on input |
| vpp_hi | input | 1 | Programming supply is high |
| vcc_ok | input | 1 | Core supply above lockout |
| array_rdata | input | DW | Read data from the cell array |
| cell_addr | output | AW | Address to the cell array |
| cell_wdata | output | DW | Latched program data |
| dout | output | DW | Read data toward the pins |
| dout_en | output | 1 | Output driver enable |
| mode | output | 4 | Current mode code |
| busy | output | 1 | A program or erase pulse is running |
| pulse_erase | output | 1 | Last pulse started was an erase |
| pulse_stop | output | 1 | One-cycle strobe after a pulse ends |

## Verification
The assertions check on every cycle that the pulse flags agree with each other, and that `busy` only coexists with the program or erase modes. They also check that a held-off supply-ok or programming-supply flag freezes the mode, that a chip enable held high two cycles earlier keeps the driver off, and that the mode code stays legal. Only the scenarios can show the two-step erase confirm, the double reset code, the split address/data latching of a program write, and verify addresses surviving later writes. The same holds for the exact timer lengths and the signature codes, all of which the cycle-accurate bench model compares every clock.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  typedef enum logic [3:0] {
    M_READ    = 4'd0,
    M_SIG     = 4'd1,
    M_ESETUP  = 4'd2,
    M_ERASE   = 4'd3,
    M_EVERIFY = 4'd4,
    M_PSETUP  = 4'd5,
    M_PROG    = 4'd6,
    M_PVERIFY = 4'd7,
    M_RST1    = 4'd8
  } fcmd_mode_e;

  localparam logic [7:0] CMD_READ  = 8'h00;
  localparam logic [7:0] CMD_SIG   = 8'h90;
  localparam logic [7:0] CMD_ESET  = 8'h20;
  localparam logic [7:0] CMD_EVER  = 8'hA0;
  localparam logic [7:0] CMD_PSET  = 8'h40;
  localparam logic [7:0] CMD_PVER  = 8'hC0;
  localparam logic [7:0] CMD_RST   = 8'hFF;

  localparam logic [15:0] SIG_MAKER  = 16'h0031;
  localparam logic [15:0] SIG_DEVICE = 16'h0051;
endpackage

// File: rtl/fcmd_sync.sv
module fcmd_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fcmd_pulse_timer.sv
module fcmd_pulse_timer #(
  parameter int PGM_TICKS = 1000,
  parameter int ERS_TICKS = 950000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic go_erase,
  input  logic abort,
  output logic busy,
  output logic is_erase,
  output logic stop
);
  localparam int MAXT = (PGM_TICKS > ERS_TICKS) ? PGM_TICKS : ERS_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] PGM_LOAD = CW'(PGM_TICKS - 1);
  localparam logic [CW-1:0] ERS_LOAD = CW'(ERS_TICKS - 1);

  logic          run_q, run_d;
  logic          ers_q, ers_d;
  logic          stop_q, stop_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    run_d  = run_q;
    ers_d  = ers_q;
    cnt_d  = cnt_q;
    stop_d = 1'b0;
    if (go) begin
      run_d = 1'b1;
      ers_d = go_erase;
      cnt_d = go_erase ? ERS_LOAD : PGM_LOAD;
    end else if (run_q) begin
      if (abort || cnt_q == '0) begin
        run_d  = 1'b0;
        stop_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ers_q  <= 1'b0;
      stop_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      run_q  <= run_d;
      ers_q  <= ers_d;
      stop_q <= stop_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy     = run_q;
  assign is_erase = ers_q;
  assign stop     = stop_q;
endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
  import fcmd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_s,
  input  logic          oe_s,
  input  logic          we_s,
  input  logic          vpp_s,
  input  logic          vcc_s,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] data_s,
  input  logic          tmr_busy,
  output fcmd_mode_e    mode,
  output logic [AW-1:0] lat_addr,
  output logic [DW-1:0] lat_data,
  output logic          go,
  output logic          go_erase,
  output logic          abort
);
  fcmd_mode_e    mode_q, mode_d;
  logic          we_prev_q;
  logic [AW-1:0] fall_addr_q;
  logic [AW-1:0] lat_addr_q;
  logic [DW-1:0] lat_data_q;
  logic          wr_ok, we_fall, we_rise;
  logic          fall_en, lat_addr_en, lat_data_en;
  logic [7:0]    cmd;

  assign wr_ok   = ~ce_s & oe_s & vcc_s;
  assign we_fall = we_prev_q & ~we_s & wr_ok;
  assign we_rise = ~we_prev_q & we_s & wr_ok & vpp_s;
  assign fall_en = we_fall;
  assign cmd     = data_s[7:0];

  always_comb begin
    mode_d      = mode_q;
    lat_addr_en = 1'b0;
    lat_data_en = 1'b0;
    go          = 1'b0;
    go_erase    = 1'b0;
    abort       = 1'b0;
    if (we_rise) begin
      abort = tmr_busy;
      case (mode_q)
        M_PSETUP: begin
          mode_d      = M_PROG;
          lat_addr_en = 1'b1;
          lat_data_en = 1'b1;
          go          = 1'b1;
        end
        M_ESETUP: begin
          if (cmd == CMD_ESET) begin
            mode_d   = M_ERASE;
            go       = 1'b1;
            go_erase = 1'b1;
          end else if (cmd == CMD_RST) begin
            mode_d = M_RST1;
          end else begin
            mode_d = M_READ;
          end
        end
        default: begin
          case (cmd)
            CMD_READ: mode_d = M_READ;
            CMD_SIG:  mode_d = M_SIG;
            CMD_ESET: mode_d = M_ESETUP;
            CMD_PSET: mode_d = M_PSETUP;
            CMD_EVER: begin
              mode_d      = M_EVERIFY;
              lat_addr_en = 1'b1;
            end
            CMD_PVER: mode_d = M_PVERIFY;
            CMD_RST:  mode_d = (mode_q == M_RST1) ? M_READ : M_RST1;
            default:  mode_d = M_READ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_READ;
      we_prev_q <= 1'b1;
    end else begin
      mode_q    <= mode_d;
      we_prev_q <= we_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_addr_q <= '0;
      lat_addr_q  <= '0;
      lat_data_q  <= '0;
    end else begin
      if (fall_en)     fall_addr_q <= addr_s;
      if (lat_addr_en) lat_addr_q  <= fall_addr_q;
      if (lat_data_en) lat_data_q  <= data_s;
    end
  end

  assign mode     = mode_q;
  assign lat_addr = lat_addr_q;
  assign lat_data = lat_data_q;
endmodule

// File: rtl/fcmd_rdpath.sv
module fcmd_rdpath
  import fcmd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  fcmd_mode_e    mode,
  input  logic          ce_s,
  input  logic          oe_s,
  input  logic          we_s,
  input  logic [AW-1:0] addr_s,
  input  logic [AW-1:0] lat_addr,
  input  logic [DW-1:0] array_rdata,
  output logic [AW-1:0] cell_addr,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  logic          use_latched;
  logic [DW-1:0] sig_word;

  assign use_latched = (mode == M_PROG) || (mode == M_PVERIFY) || (mode == M_EVERIFY);
  assign cell_addr   = use_latched ? lat_addr : addr_s;
  assign dout_en     = ~ce_s & ~oe_s & we_s;

  always_comb begin
    if (addr_s == AW'(0))      sig_word = DW'(SIG_MAKER);
    else if (addr_s == AW'(1)) sig_word = DW'(SIG_DEVICE);
    else                       sig_word = '0;
  end

  assign dout = (mode == M_SIG) ? sig_word : array_rdata;
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fcmd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PGM_TICKS = 1000,
  parameter int ERS_TICKS = 950000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          vpp_hi,
  input  logic          vcc_ok,
  input  logic [DW-1:0] array_rdata,
  output logic [AW-1:0] cell_addr,
  output logic [DW-1:0] cell_wdata,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic [3:0]    mode,
  output logic          busy,
  output logic          pulse_erase,
  output logic          pulse_stop
);
  localparam int CTW = 5;
  localparam int BW  = AW + DW;
  localparam logic [CTW-1:0] CT_IDLE = 5'b11100;

  logic [CTW-1:0] ct_s;
  logic [BW-1:0]  bus_s;
  logic           ce_s, oe_s, we_s, vpp_s, vcc_s;
  logic [AW-1:0]  addr_s, lat_addr;
  logic [DW-1:0]  data_s;
  fcmd_mode_e     mode_cur;
  logic           go, go_erase, abort, tmr_busy;

  fcmd_sync #(.W(CTW), .STAGES(SYNC_STAGES), .RST_VAL(CT_IDLE)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n),
    .d({ce_n, oe_n, we_n, vpp_hi, vcc_ok}),
    .q(ct_s)
  );

  fcmd_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
    .clk(clk), .rst_n(rst_n),
    .d({addr, din}),
    .q(bus_s)
  );

  assign {ce_s, oe_s, we_s, vpp_s, vcc_s} = ct_s;
  assign {addr_s, data_s} = bus_s;

  fcmd_decoder #(.AW(AW), .DW(DW)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s), .vpp_s(vpp_s), .vcc_s(vcc_s),
    .addr_s(addr_s), .data_s(data_s), .tmr_busy(tmr_busy),
    .mode(mode_cur), .lat_addr(lat_addr), .lat_data(cell_wdata),
    .go(go), .go_erase(go_erase), .abort(abort)
  );

  fcmd_pulse_timer #(.PGM_TICKS(PGM_TICKS), .ERS_TICKS(ERS_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .go(go), .go_erase(go_erase), .abort(abort),
    .busy(tmr_busy), .is_erase(pulse_erase), .stop(pulse_stop)
  );

  fcmd_rdpath #(.AW(AW), .DW(DW)) u_rd (
    .mode(mode_cur), .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s),
    .addr_s(addr_s), .lat_addr(lat_addr), .array_rdata(array_rdata),
    .cell_addr(cell_addr), .dout(dout), .dout_en(dout_en)
  );

  assign mode = mode_cur;
  assign busy = tmr_busy;
endmodule

// File: rtl/fcmd_checker.sv
module fcmd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       vpp_hi,
  input logic       vcc_ok,
  input logic [3:0] mode,
  input logic       busy,
  input logic       pulse_stop,
  input logic       dout_en
);
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_stop |-> !busy);

  assert_fall_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> pulse_stop);

  assert_busy_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mode == 4'd6 || mode == 4'd3));

  assert_standby_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n, 2) |-> !dout_en);

  assert_lockout_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vcc_ok, 3) |-> $stable(mode));

  assert_vpp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vpp_hi, 3) |-> $stable(mode));

  assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 4'd8);
endmodule

bind flash_cmd_if fcmd_checker chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .vpp_hi(vpp_hi), .vcc_ok(vcc_ok),
  .mode(mode), .busy(busy), .pulse_stop(pulse_stop), .dout_en(dout_en)
);

// File: tb/flash_cmd_if_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_if_tb_top;
  localparam int PT = 40;
  localparam int ET = 120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic vpp_hi = 1'b1, vcc_ok = 1'b1;
  logic [15:0] addr = '0, din = '0;
  logic [15:0] array_rdata, cell_addr, cell_wdata, dout;
  logic dout_en, busy, pulse_erase, pulse_stop;
  logic [3:0] mode;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int run_len = 0, last_len = 0;

  always #5 clk = ~clk;

  assign array_rdata = cell_addr ^ 16'hA5A5;

  flash_cmd_if #(.PGM_TICKS(PT), .ERS_TICKS(ET)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .vpp_hi(vpp_hi), .vcc_ok(vcc_ok),
    .array_rdata(array_rdata), .cell_addr(cell_addr), .cell_wdata(cell_wdata),
    .dout(dout), .dout_en(dout_en), .mode(mode), .busy(busy),
    .pulse_erase(pulse_erase), .pulse_stop(pulse_stop)
  );

  // ---------------- behavioural reference model ----------------
  typedef struct packed {
    logic ce, oe, we, vpp, vcc;
    logic [15:0] a, d;
  } pins_t;
  pins_t pq[$];
  pins_t cur;
  logic mprev;
  int mmode, mcnt;
  logic mbusy, mers, mstop;
  logic [15:0] mfall, mlat, mdat;

  function automatic pins_t idle_pins();
    pins_t p;
    p = '{ce:1, oe:1, we:1, vpp:0, vcc:0, a:0, d:0};
    return p;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pq = {};
      pq.push_back(idle_pins());
      pq.push_back(idle_pins());
      mprev = 1; mmode = 0; mcnt = 0; mbusy = 0; mers = 0; mstop = 0;
      mfall = 0; mlat = 0; mdat = 0;
    end else begin
      pins_t p;
      logic ok, fall, rise, go, goe, ab;
      int nm;
      logic [7:0] c;
      p = pq[1];
      ok = !p.ce && p.oe && p.vcc;
      fall = mprev && !p.we && ok;
      rise = !mprev && p.we && ok && p.vpp;
      c = p.d[7:0];
      go = 0; goe = 0; ab = rise && mbusy; nm = mmode;
      if (rise) begin
        if (mmode == 5) begin nm = 6; mlat = mfall; mdat = p.d; go = 1; end
        else if (mmode == 2) begin
          if (c == 8'h20) begin nm = 3; go = 1; goe = 1; end
          else if (c == 8'hFF) nm = 8;
          else nm = 0;
        end else begin
          case (c)
            8'h00: nm = 0;
            8'h90: nm = 1;
            8'h20: nm = 2;
            8'h40: nm = 5;
            8'hA0: begin nm = 4; mlat = mfall; end
            8'hC0: nm = 7;
            8'hFF: nm = (mmode == 8) ? 0 : 8;
            default: nm = 0;
          endcase
        end
      end
      mstop = 0;
      if (go) begin mbusy = 1; mers = goe; mcnt = goe ? ET - 1 : PT - 1; end
      else if (mbusy) begin
        if (ab || mcnt == 0) begin mbusy = 0; mstop = 1; end
        else mcnt = mcnt - 1;
      end
      if (fall) mfall = p.a;
      mmode = nm;
      mprev = p.we;
      cur = '{ce:ce_n, oe:oe_n, we:we_n, vpp:vpp_hi, vcc:vcc_ok, a:addr, d:din};
      pq.pop_back();
      pq.push_front(cur);
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && pq.size() == 2) begin
      pins_t p;
      logic [15:0] ea, ed;
      logic een;
      p = pq[1];
      ea = (mmode == 4 || mmode == 6 || mmode == 7) ? mlat : p.a;
      een = !p.ce && !p.oe && p.we;
      if (mmode == 1) ed = (p.a == 0) ? 16'h0031 : (p.a == 1) ? 16'h0051 : 16'h0000;
      else ed = ea ^ 16'hA5A5;
      chk("R2 model mode", {12'd0, mode}, 16'(mmode));
      chk("R9 model busy", {15'd0, busy}, {15'd0, mbusy});
      chk("R9 model stop", {15'd0, pulse_stop}, {15'd0, mstop});
      chk("R9 model kind", {15'd0, pulse_erase}, {15'd0, mers});
      chk("R11 model cell_addr", cell_addr, ea);
      chk("R7 model wdata", cell_wdata, mdat);
      chk("R11 model dout_en", {15'd0, dout_en}, {15'd0, een});
      if (een) chk(mmode == 1 ? "R10 model dout" : "R11 model dout", dout, ed);
    end
    if (busy) run_len++;
    else if (run_len != 0) begin last_len = run_len; run_len = 0; end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic oe_v);
    ce_n = 0; oe_n = oe_v; addr = a; din = d;
    tick(2); we_n = 0;
    tick(3); we_n = 1;
    tick(3); ce_n = 1; oe_n = 1;
    tick(3);
  endtask

  task automatic rd_on(input logic [15:0] a);
    ce_n = 0; oe_n = 0; addr = a;
    tick(3);
  endtask

  task automatic rd_off();
    ce_n = 1; oe_n = 1;
    tick(2);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    chk("R1 reset mode", {12'd0, mode}, 16'd0);
    chk("R1 reset busy", {15'd0, busy}, 16'd0);
    chk("R1 reset dout_en", {15'd0, dout_en}, 16'd0);
    rst_n = 1;
    tick(4);

    // R11 array read and standby
    rd_on(16'h0123);
    chk("R11 read enable", {15'd0, dout_en}, 16'd1);
    chk("R11 array data", dout, 16'h0123 ^ 16'hA5A5);
    rd_off();
    chk("R11 standby driver off", {15'd0, dout_en}, 16'd0);

    // R10 signature
    wr(16'h0000, 16'h0090, 1);
    chk("R2 signature mode", {12'd0, mode}, 16'd1);
    rd_on(16'h0000); chk("R10 maker code", dout, 16'h0031); rd_off();
    rd_on(16'h0001); chk("R10 device code", dout, 16'h0051); rd_off();
    rd_on(16'h0002); chk("R10 other addr", dout, 16'h0000); rd_off();

    // R2 unknown code -> read
    wr(16'h0000, 16'h0055, 1);
    chk("R2 unknown to read", {12'd0, mode}, 16'd0);

    // R3 programming supply low
    vpp_hi = 0;
    wr(16'h0000, 16'h0090, 1);
    chk("R3 vpp low ignored", {12'd0, mode}, 16'd0);
    vpp_hi = 1;
    // R3 supply lockout
    vcc_ok = 0;
    wr(16'h0000, 16'h0040, 1);
    chk("R3 lockout ignored", {12'd0, mode}, 16'd0);
    vcc_ok = 1;
    tick(3);

    // R4 write inhibit with CE and OE low
    wr(16'h0000, 16'h0090, 0);
    chk("R4 inhibit", {12'd0, mode}, 16'd0);

    // R7 program aborted by verify command, R12 verify address
    wr(16'h0000, 16'h0040, 1);
    chk("R7 program setup", {12'd0, mode}, 16'd5);
    wr(16'h1234, 16'hBEEF, 1);
    chk("R7 program mode", {12'd0, mode}, 16'd6);
    chk("R7 busy", {15'd0, busy}, 16'd1);
    chk("R7 latched data", cell_wdata, 16'hBEEF);
    chk("R7 latched addr", cell_addr, 16'h1234);
    chk("R9 kind program", {15'd0, pulse_erase}, 16'd0);
    wr(16'h0055, 16'h00C0, 1);
    chk("R7 pulse ended by write", {15'd0, busy}, 16'd0);
    chk("R12 verify mode", {12'd0, mode}, 16'd7);
    rd_on(16'h0077);
    chk("R12 verify addr kept", cell_addr, 16'h1234);
    chk("R12 verify data", dout, 16'h1234 ^ 16'hA5A5);
    rd_off();

    // R9 program expiry
    wr(16'h0000, 16'h0040, 1);
    wr(16'h0042, 16'h1111, 1);
    chk("R9 program running", {15'd0, busy}, 16'd1);
    tick(PT + 5);
    chk("R9 program length", 16'(last_len), 16'(PT));
    chk("R9 program done", {15'd0, busy}, 16'd0);

    // R5 erase confirm and R9 erase expiry, R8 verify
    wr(16'h0000, 16'h0020, 1);
    chk("R5 erase setup", {12'd0, mode}, 16'd2);
    wr(16'h0000, 16'h0020, 1);
    chk("R5 erase mode", {12'd0, mode}, 16'd3);
    chk("R9 kind erase", {15'd0, pulse_erase}, 16'd1);
    tick(ET + 5);
    chk("R9 erase length", 16'(last_len), 16'(ET));
    wr(16'h0300, 16'h00A0, 1);
    chk("R8 erase verify mode", {12'd0, mode}, 16'd4);
    chk("R8 verify addr", cell_addr, 16'h0300);

    // R8 verify ends running erase
    wr(16'h0000, 16'h0020, 1);
    wr(16'h0000, 16'h0020, 1);
    chk("R8 erase running", {15'd0, busy}, 16'd1);
    wr(16'h0456, 16'h00A0, 1);
    chk("R8 erase stopped", {15'd0, busy}, 16'd0);
    chk("R8 short pulse", {15'd0, 1'(last_len < ET)}, 16'd1);
    chk("R8 verify addr 2", cell_addr, 16'h0456);

    // R5 wrong confirm
    wr(16'h0000, 16'h0020, 1);
    wr(16'h0000, 16'h0090, 1);
    chk("R5 wrong confirm read", {12'd0, mode}, 16'd0);
    chk("R5 no pulse", {15'd0, busy}, 16'd0);

    // R6 double reset aborts erase
    wr(16'h0000, 16'h0020, 1);
    wr(16'h0000, 16'h0020, 1);
    wr(16'h0000, 16'h00FF, 1);
    chk("R6 first reset", {12'd0, mode}, 16'd8);
    chk("R6 pulse aborted", {15'd0, busy}, 16'd0);
    wr(16'h0000, 16'h00FF, 1);
    chk("R6 back to read", {12'd0, mode}, 16'd0);
    // R6 single reset then other command
    wr(16'h0000, 16'h00FF, 1);
    wr(16'h0000, 16'h0090, 1);
    chk("R6 single reset then sig", {12'd0, mode}, 16'd1);

    tick(5);
    done = 1;
    summary();
    $finish;
  end
endmodule